// File: doc/BRIEF.md
# Symmetric Bus Agent Request Arbiter

This block is the request-side controller of one symmetric agent sharing a multi-agent bus. It learns its own agent number when reset is released, runs a rotating-priority ownership tracker for all symmetric agents, and decides in which cycles it may start a new transaction. It emits a one-cycle issue pulse for each transaction it starts and keeps a count of transactions still in flight.

Three shared conditions can hold the agent back. A priority-agent request stops new issue unless a locked sequence is in progress. A stall line, driven by any agent that cannot take more work, is sampled only on alternate cycles. A bus-initialization line, when its observation is enabled, clears ownership and lock state but leaves the in-flight count alone. When observation is disabled, that line has no effect on arbitration and is only reported on a flag for error handling at a higher level. All signals are active-high, and the block runs on a single clock.

Top module: `bus_req_agent`

## Requirements
- R1: While `rst` is high, the agent takes as its ID the lowest index whose `peer_req` bit is set, or 0 if none is set. `agent_id` keeps that value after reset.
- R2: The effective request vector is `peer_req` with bit `agent_id` replaced by `local_req`. A new owner is the first requester found scanning upward, with wrap-around, from the last owner plus one. After reset the last owner is 0, and no agent owns the bus.
- R3: An owner keeps the bus for as long as its effective request bit stays set. When no agent requests, the bus has no owner.
- R4: While `prio_req` is high, ownership is frozen and no issue starts unless `lock_held` is set.
- R5: A phase bit is cleared by reset and toggles every cycle. `stall_in` is captured only on edges where the phase is 1. A captured stall blocks issue.
- R6: `stall_out` copies `local_full` only on the same sampling edges.
- R7: `issue` rises one cycle after a cycle in which all of these hold: the agent owns the bus, `local_req` is set, no stall is captured, the priority condition of R4 allows issue, and `issue` is low. As a result, `issue` is never high for two cycles in a row.
- R8: `lock_held` is set when an issue starts with `lock_in` high and clears when `lock_in` is low. While it is set, ownership is frozen.
- R9: When `binit_in` and `binit_obs_en` are both high, ownership and the last owner reset to 0 and `lock_held` clears on the next edge.
- R10: `outstanding` increases by one on each `issue` cycle and decreases on `txn_done` when it is nonzero, modulo 2^CNT_W. Bus-init never changes it.
- R11: With `binit_obs_en` low, `binit_in` has no effect on ownership or lock state, and `binit_ignored` is high in the cycle after it is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| peer_req | input | N_AGENTS | Observed request lines of all agents; also used for ID capture during reset |
| local_req | input | 1 | This agent has transactions to issue |
| lock_in | input | 1 | The current or next transaction is part of a locked sequence |
| prio_req | input | 1 | Priority agent request |
| stall_in | input | 1 | Shared stall line as observed |
| local_full | input | 1 | This agent cannot accept new transactions |
| binit_in | input | 1 | Bus initialization line |
| binit_obs_en | input | 1 | Configuration: act on bus initialization |
| txn_done | input | 1 | One in-flight transaction has completed |
| agent_id | output | $clog2(N_AGENTS) | Captured agent number |
| owns_bus | output | 1 | This agent is the current symmetric owner |
| issue | output | 1 | One-cycle strobe that starts a transaction |
| stall_out | output | 1 | Stall request driven by this agent |
| lock_held | output | 1 | A locked sequence is in progress |
| binit_ignored | output | 1 | Bus init was seen while observation was disabled |
| outstanding | output | CNT_W | Count of in-flight transactions |

## Verification
A corrupted last-owner or owner register first shows as a wrong `owns_bus` value on the next arbitration decision, usually within a cycle or two when several agents request. A stuck phase bit shows as `stall_out` or issue gating changing on the wrong edge, within two cycles of a stall transition. Lock or bus-init errors show as `issue` pulses under an active priority request, or as `owns_bus` or `lock_held` surviving an enabled init for more than one edge. Tracking errors show in `outstanding` as soon as an issue or completion arrives.

// File: rtl/bus_agent_pkg.sv
package bus_agent_pkg;
  localparam int MAXA = 32;

  // Lowest set index among the first n bits, 0 when none is set.
  function automatic int first_set(input logic [MAXA-1:0] v, input int n);
    first_set = 0;
    for (int i = n - 1; i >= 0; i--)
      if (v[i]) first_set = i;
  endfunction

  // First requester after 'last' in rotating order, 'last' if it is the only one.
  function automatic int rr_pick(input logic [MAXA-1:0] req, input int last, input int n);
    rr_pick = last;
    for (int k = n; k >= 1; k--)
      if (req[(last + k) % n]) rr_pick = (last + k) % n;
  endfunction
endpackage

// File: rtl/id_capture.sv
module id_capture #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] lines,
  output logic [IDW-1:0] id
);
  import bus_agent_pkg::*;

  always_ff @(posedge clk)
    if (rst) id <= IDW'(first_set(MAXA'(lines), N));
endmodule

// File: rtl/rr_owner.sv
module rr_owner #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   req,
  input  logic           clear,
  input  logic           freeze,
  input  logic [IDW-1:0] my_id,
  output logic           owner_valid,
  output logic [IDW-1:0] owner_id,
  output logic           owns
);
  import bus_agent_pkg::*;

  logic [IDW-1:0] last_owner;
  logic [IDW-1:0] next_pick;
  logic           owner_still;

  assign next_pick   = IDW'(rr_pick(MAXA'(req), int'(last_owner), N));
  assign owner_still = owner_valid & req[owner_id];
  assign owns        = owner_valid & (owner_id == my_id);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner_valid <= 1'b0;
      owner_id    <= '0;
      last_owner  <= '0;
    end else if (clear) begin
      owner_valid <= 1'b0;
      owner_id    <= '0;
      last_owner  <= '0;
    end else if (freeze || owner_still) begin
      owner_valid <= owner_valid;
    end else if (|req) begin
      owner_valid <= 1'b1;
      owner_id    <= next_pick;
      last_owner  <= next_pick;
    end else begin
      owner_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/stall_phase.sv
module stall_phase (
  input  logic clk,
  input  logic rst,
  input  logic stall_in,
  input  logic local_full,
  output logic phase,
  output logic stall_seen,
  output logic stall_out
);
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= 1'b0;
      stall_seen <= 1'b0;
      stall_out  <= 1'b0;
    end else begin
      phase <= ~phase;
      if (phase) begin
        stall_seen <= stall_in;
        stall_out  <= local_full;
      end
    end
  end
endmodule

// File: rtl/txn_tracker.sv
module txn_tracker #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] count
);
  logic dec_ok;
  assign dec_ok = dec & (count != '0);

  always_ff @(posedge clk) begin
    if (rst)                count <= '0;
    else if (inc && !dec_ok) count <= count + 1'b1;
    else if (!inc && dec_ok) count <= count - 1'b1;
  end
endmodule

// File: rtl/bus_req_agent.sv
module bus_req_agent #(
  parameter int N_AGENTS = 4,
  parameter int CNT_W    = 4,
  localparam int IDW     = (N_AGENTS > 1) ? $clog2(N_AGENTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_AGENTS-1:0] peer_req,
  input  logic                local_req,
  input  logic                lock_in,
  input  logic                prio_req,
  input  logic                stall_in,
  input  logic                local_full,
  input  logic                binit_in,
  input  logic                binit_obs_en,
  input  logic                txn_done,
  output logic [IDW-1:0]      agent_id,
  output logic                owns_bus,
  output logic                issue,
  output logic                stall_out,
  output logic                lock_held,
  output logic                binit_ignored,
  output logic [CNT_W-1:0]    outstanding
);
  logic [N_AGENTS-1:0] eff_req;
  logic                arb_clear;
  logic                arb_freeze;
  logic                issue_go;
  logic                stall_seen;
  logic                sample_phase;
  logic                owner_valid;
  logic [IDW-1:0]      owner_id;

  id_capture #(.N(N_AGENTS), .IDW(IDW)) u_id (
    .clk(clk), .rst(rst), .lines(peer_req), .id(agent_id));

  always_comb begin
    eff_req           = peer_req;
    eff_req[agent_id] = local_req;
  end

  assign arb_clear  = binit_in & binit_obs_en;
  assign arb_freeze = prio_req | lock_held;

  rr_owner #(.N(N_AGENTS), .IDW(IDW)) u_arb (
    .clk(clk), .rst(rst), .req(eff_req), .clear(arb_clear),
    .freeze(arb_freeze), .my_id(agent_id), .owner_valid(owner_valid),
    .owner_id(owner_id), .owns(owns_bus));

  stall_phase u_stall (
    .clk(clk), .rst(rst), .stall_in(stall_in), .local_full(local_full),
    .phase(sample_phase), .stall_seen(stall_seen), .stall_out(stall_out));

  assign issue_go = owns_bus & local_req & ~stall_seen
                  & (~prio_req | lock_held) & ~issue;

  always_ff @(posedge clk) begin
    if (rst) begin
      issue         <= 1'b0;
      lock_held     <= 1'b0;
      binit_ignored <= 1'b0;
    end else begin
      issue         <= issue_go;
      binit_ignored <= binit_in & ~binit_obs_en;
      if (arb_clear)                lock_held <= 1'b0;
      else if (issue_go && lock_in) lock_held <= 1'b1;
      else if (!lock_in)            lock_held <= 1'b0;
    end
  end

  txn_tracker #(.CW(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .inc(issue), .dec(txn_done), .count(outstanding));
endmodule

// File: rtl/bus_agent_checker.sv
module bus_agent_checker #(
  parameter int IDW = 2,
  parameter int CW  = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           local_req,
  input logic           prio_req,
  input logic           binit_in,
  input logic           binit_obs_en,
  input logic           txn_done,
  input logic [IDW-1:0] agent_id,
  input logic           owns_bus,
  input logic           issue,
  input logic           stall_out,
  input logic           lock_held,
  input logic           binit_ignored,
  input logic [CW-1:0]  outstanding,
  input logic           stall_seen,
  input logic           sample_phase
);
  assert_id_stable_R1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(agent_id));
  assert_owner_kept_R3: assert property (@(posedge clk) disable iff (rst)
    owns_bus && local_req && !(binit_in && binit_obs_en) |=> owns_bus);
  assert_prio_block_R4: assert property (@(posedge clk) disable iff (rst)
    issue |-> $past(!prio_req || lock_held));
  assert_stall_block_R5: assert property (@(posedge clk) disable iff (rst)
    issue |-> $past(!stall_seen));
  assert_stall_edge_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(stall_seen) |-> $past(sample_phase));
  assert_drive_edge_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(stall_out) |-> $past(sample_phase));
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    issue |=> !issue);
  assert_issue_owner_R7: assert property (@(posedge clk) disable iff (rst)
    issue |-> $past(owns_bus && local_req));
  assert_binit_clear_R9: assert property (@(posedge clk) disable iff (rst)
    binit_in && binit_obs_en |=> !owns_bus && !lock_held);
  assert_binit_keeps_count_R10: assert property (@(posedge clk) disable iff (rst)
    binit_in && !issue && !txn_done |=> $stable(outstanding));
  assert_binit_flag_R11: assert property (@(posedge clk) disable iff (rst)
    binit_in && !binit_obs_en |=> binit_ignored);
endmodule

bind bus_req_agent bus_agent_checker #(.IDW(IDW), .CW(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .local_req(local_req), .prio_req(prio_req),
  .binit_in(binit_in), .binit_obs_en(binit_obs_en), .txn_done(txn_done),
  .agent_id(agent_id), .owns_bus(owns_bus), .issue(issue),
  .stall_out(stall_out), .lock_held(lock_held),
  .binit_ignored(binit_ignored), .outstanding(outstanding),
  .stall_seen(stall_seen), .sample_phase(sample_phase));

// File: tb/bus_req_agent_bench.sv
module bus_req_agent_bench;
  localparam int  N   = 4;
  localparam int  IDW = 2;
  localparam time CLK = 20ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] peer_req = '0;
  logic local_req = 0, lock_in = 0, prio_req = 0, stall_in = 0, local_full = 0;
  logic binit_in = 0, binit_obs_en = 1, txn_done = 0;
  logic [IDW-1:0] agent_id;
  logic owns_bus, issue, stall_out, lock_held, binit_ignored;
  logic [3:0] outstanding;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK / 2) clk = ~clk;

  bus_req_agent #(.N_AGENTS(N), .CNT_W(4)) u_bus_req_agent (
    .clk(clk), .rst(rst), .peer_req(peer_req), .local_req(local_req),
    .lock_in(lock_in), .prio_req(prio_req), .stall_in(stall_in),
    .local_full(local_full), .binit_in(binit_in), .binit_obs_en(binit_obs_en),
    .txn_done(txn_done), .agent_id(agent_id), .owns_bus(owns_bus),
    .issue(issue), .stall_out(stall_out), .lock_held(lock_held),
    .binit_ignored(binit_ignored), .outstanding(outstanding));

  // Expected-value model built from the requirements.
  int m_id, m_oid, m_last;
  bit m_ov, m_phase, m_stall, m_sout, m_issue, m_lock, m_flag;
  logic [3:0] m_cnt;

  function automatic int ref_id(input logic [N-1:0] v);
    int r = 0;
    bit found = 0;
    for (int i = 0; i < N; i++) if (v[i] && !found) begin r = i; found = 1; end
    return r;
  endfunction

  function automatic int ref_next(input logic [N-1:0] v, input int last);
    logic [2*N-1:0] dbl = {v, v};
    for (int s = 1; s <= N; s++)
      if (dbl[last + s]) return (last + s >= N) ? last + s - N : last + s;
    return last;
  endfunction

  always @(posedge clk) begin
    logic [N-1:0] eff;
    bit owns, go, en_init;
    if (rst) begin
      m_id = ref_id(peer_req);
      m_ov = 0; m_oid = 0; m_last = 0; m_phase = 0; m_stall = 0; m_sout = 0;
      m_issue = 0; m_lock = 0; m_flag = 0; m_cnt = 0;
    end else begin
      eff = peer_req;
      eff[m_id] = local_req;
      owns = m_ov && (m_oid == m_id);
      go = owns && local_req && !m_stall && (!prio_req || m_lock) && !m_issue;
      en_init = binit_in && binit_obs_en;
      if (m_issue && !(txn_done && m_cnt != 0)) m_cnt = m_cnt + 1;
      else if (!m_issue && txn_done && m_cnt != 0) m_cnt = m_cnt - 1;
      if (en_init) begin m_ov = 0; m_oid = 0; m_last = 0; end
      else if (prio_req || m_lock || (m_ov && eff[m_oid])) ;
      else if (eff != 0) begin m_oid = ref_next(eff, m_last); m_last = m_oid; m_ov = 1; end
      else m_ov = 0;
      if (en_init) m_lock = 0;
      else if (go && lock_in) m_lock = 1;
      else if (!lock_in) m_lock = 0;
      if (m_phase) begin m_stall = stall_in; m_sout = local_full; end
      m_phase = !m_phase;
      m_flag = binit_in && !binit_obs_en;
      m_issue = go;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    check("R1", "agent_id", int'(agent_id), m_id);
    check("R2", "owns_bus", int'(owns_bus), int'(m_ov && m_oid == m_id));
    check("R7", "issue", int'(issue), int'(m_issue));
    check("R6", "stall_out", int'(stall_out), int'(m_sout));
    check("R8", "lock_held", int'(lock_held), int'(m_lock));
    check("R11", "binit_ignored", int'(binit_ignored), int'(m_flag));
    check("R10", "outstanding", int'(outstanding), int'(m_cnt));
  endtask

  task automatic do_reset(input logic [N-1:0] pattern);
    rst = 1; peer_req = pattern; local_req = 0; prio_req = 0; binit_in = 0;
    lock_in = 0; stall_in = 0; local_full = 0; txn_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R1", "captured id", int'(agent_id), ref_id(pattern));
    check("R2", "no owner after reset", int'(owns_bus), 0);
    check("R10", "count after reset", int'(outstanding), 0);
  endtask

  task automatic rand_run(input int cycles, input bit obs_en, input int prio_pct);
    binit_obs_en = obs_en;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare_all();
      peer_req   = N'($urandom_range(0, (1 << N) - 1) & $urandom_range(0, (1 << N) - 1));
      local_req  = ($urandom_range(0, 99) < 70);
      lock_in    = ($urandom_range(0, 99) < 30) ? ~lock_in : lock_in;
      if ($urandom_range(0, 99) < 8) prio_req = ($urandom_range(0, 99) < prio_pct);
      stall_in   = ($urandom_range(0, 99) < 25);
      local_full = ($urandom_range(0, 99) < 40);
      binit_in   = ($urandom_range(0, 99) < 4);
      txn_done   = ($urandom_range(0, 99) < 45);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    // Directed R1/R2: id 1, agents 0 and 1 request; after reset last owner is 0 so 1 wins.
    do_reset(4'b0010);
    peer_req = 4'b0001; local_req = 1;
    @(negedge clk);
    check("R2", "rotation picks agent 1 after 0", int'(owns_bus), 1);
    // R5/R7: a stall captured on the sampling edge blocks issue.
    stall_in = 1;
    repeat (2) @(negedge clk);
    stall_in = 0;
    @(negedge clk);
    check("R5", "no issue under captured stall", int'(issue), 0);
    // R9: enabled init drops ownership, count untouched.
    binit_obs_en = 1; binit_in = 1; local_req = 0;
    @(negedge clk);
    binit_in = 0;
    check("R9", "owner cleared by init", int'(owns_bus), 0);
    // Model-driven random segments, several IDs and both init modes.
    do_reset(4'b0110);  rand_run(3000, 1, 30);
    do_reset(4'b0000);  rand_run(3000, 0, 20);
    do_reset(4'b1000);  rand_run(3000, 1, 50);
    do_reset(4'b0010);  rand_run(3000, 0, 10);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK * 190000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule